// File: doc/BRIEF.md
# Receive packet filter engine

This block sits behind the sync-word detector of a sub-gigahertz receiver. Once sync has been found it takes the byte stream that follows and frames it as a packet. The length comes from one of three places: a programmed value, the first received byte, or nowhere at all, in which case reception runs until it is stopped by hand. The block can also reject packets whose first payload byte does not match a node address, and it checks a CRC-16 over everything after sync. Accepted bytes go into a receive FIFO through a write port that the block drives itself.

The block owns the FIFO write pointer and a commit pointer. The commit pointer marks the end of the last complete packet. If a packet is discarded because its length is too large or its address is wrong, the write pointer returns to the commit pointer and the block asks the receiver to restart. If the CRC fails and auto-flush is on, the block empties the whole FIFO. It can append two status bytes to each packet: the signal strength byte, then a byte that holds the CRC result and the link quality value. Configuration inputs must be held stable from the sync strobe until the packet ends.

Top module: `rx_pkt_filter`

## Requirements
- R1: After reset, fifo_we_o, fifo_flush_o, pkt_done_o, restart_o and crc_ok_o are 0, and fifo_cptr_o is 0.
- R2: len_mode_i = 0 selects fixed length. After sync_i, exactly len_cfg_i payload bytes are written to consecutive FIFO addresses. Each write appears on fifo_we_o/fifo_waddr_o/fifo_wdata_o one cycle after the byte is accepted.
- R3: len_mode_i = 1 selects variable length. The first byte after sync is the length and is written to the FIFO, followed by that many payload bytes. A length of 0 is legal. A length greater than len_cfg_i is not written; instead restart_o pulses one cycle after that byte, and the write pointer returns to the packet start.
- R4: len_mode_i = 2 selects infinite length. Every byte is written until stop_i. stop_i commits the bytes, pulses pkt_done_o one cycle later and sets crc_ok_o to 1. len_mode_i = 3 makes the block ignore sync_i, so nothing is written.
- R5: When addr_chk_i = 1 and the payload is not empty, the first payload byte is compared with addr_cfg_i. On a mismatch that byte is not written, restart_o pulses one cycle later, and any bytes already written for the packet are rolled back.
- R6: When crc_en_i = 1, the two bytes after the payload are the received CRC, high byte first, and they are not written. The CRC uses polynomial 0x8005, initial value 0xFFFF, bits taken MSB first, with no final inversion. It covers the length byte (in variable mode) and all payload bytes. crc_ok_o is updated together with pkt_done_o. When crc_en_i = 0, no CRC bytes are expected and crc_ok_o reads 1.
- R7: When the CRC fails and flush_en_i = 1, fifo_flush_o pulses together with pkt_done_o, and both the write pointer and fifo_cptr_o go to 0.
- R8: When app_en_i = 1, two bytes are written after the payload: rssi_i, then {crc_ok, lqi_i[6:0]}. pkt_done_o then comes four cycles after the last packet byte is accepted, instead of two.
- R9: fifo_cptr_o changes only at the end of a packet. It then holds the address that follows the packet's last written byte, or 0 after a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Sync word found strobe |
| byte_vld_i | input | 1 | Received byte valid |
| byte_i | input | 8 | Received byte |
| stop_i | input | 1 | Manual end of an infinite-length packet |
| len_mode_i | input | 2 | 0 fixed, 1 variable, 2 infinite, 3 disabled |
| len_cfg_i | input | 8 | Fixed length, or maximum variable length |
| addr_chk_i | input | 1 | Address filter enable |
| addr_cfg_i | input | 8 | Node address |
| crc_en_i | input | 1 | CRC check enable |
| flush_en_i | input | 1 | Flush FIFO on CRC failure |
| app_en_i | input | 1 | Append status bytes |
| rssi_i | input | 8 | Signal strength value |
| lqi_i | input | 7 | Link quality value |
| fifo_we_o | output | 1 | FIFO write enable |
| fifo_waddr_o | output | AW | FIFO write address |
| fifo_wdata_o | output | 8 | FIFO write data |
| fifo_cptr_o | output | AW | Committed end-of-packet pointer |
| fifo_flush_o | output | 1 | Flush whole FIFO pulse |
| pkt_done_o | output | 1 | Packet finished pulse |
| crc_ok_o | output | 1 | CRC result of last packet |
| restart_o | output | 1 | Restart receive request pulse |

## Verification
A FIFO write is due one cycle after its byte is accepted. A restart is due one cycle after the offending length or address byte. pkt_done_o is due two cycles after the last packet byte, or four when status bytes are appended. For infinite packets it is due one cycle after stop_i. The bench tags the cycle of every byte it drives, and the monitor tags the cycle of every pulse at the falling edge. The checks compare these cycle differences exactly and do not search a window.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [15:0] CRC_POLY = 16'h8005;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [1:0] {
    LEN_FIXED = 2'd0,
    LEN_VAR   = 2'd1,
    LEN_INF   = 2'd2,
    LEN_OFF   = 2'd3
  } len_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEN,
    ST_BODY,
    ST_CRC,
    ST_APP_RSSI,
    ST_APP_STAT,
    ST_DONE,
    ST_INF
  } rx_state_e;
endpackage

// File: rtl/rxf_crc16.sv
module rxf_crc16 import rxf_pkg::*; #(
  parameter logic [15:0] POLY = CRC_POLY,
  parameter logic [15:0] INIT = CRC_INIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [15:0]       crc_o
);
  logic [15:0] crc_q, crc_nx;

  // MSB-first serial division, one byte per cycle
  always_comb begin
    crc_nx = crc_q;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      if (crc_nx[15] ^ data_i[i]) crc_nx = {crc_nx[14:0], 1'b0} ^ POLY;
      else                        crc_nx = {crc_nx[14:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= INIT;
    else if (clr_i)  crc_q <= INIT;
    else if (upd_i)  crc_q <= crc_nx;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/rxf_wptr.sv
module rxf_wptr import rxf_pkg::*; #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rollback_i,
  input  logic              commit_i,
  input  logic              flush_i,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic [AW-1:0]     cptr_o,
  output logic              flush_o
);
  logic [AW-1:0]     wptr_q, cptr_q, addr_q;
  logic [BYTE_W-1:0] data_q;
  logic              we_q, flush_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      cptr_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      we_q    <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      we_q    <= 1'b0;
      flush_q <= 1'b0;
      if (flush_i) begin
        wptr_q  <= '0;
        cptr_q  <= '0;
        flush_q <= 1'b1;
      end else if (rollback_i) begin
        wptr_q <= cptr_q;
      end else begin
        if (wr_i) begin
          we_q   <= 1'b1;
          addr_q <= wptr_q;
          data_q <= wr_data_i;
          wptr_q <= wptr_q + AW'(1);
        end
        // a byte written in the commit cycle belongs to the packet
        if (commit_i) cptr_q <= wr_i ? wptr_q + AW'(1) : wptr_q;
      end
    end
  end

  assign we_o    = we_q;
  assign waddr_o = addr_q;
  assign wdata_o = data_q;
  assign cptr_o  = cptr_q;
  assign flush_o = flush_q;
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl import rxf_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              stop_i,
  input  logic [1:0]        len_mode_i,
  input  logic [BYTE_W-1:0] len_cfg_i,
  input  logic              addr_chk_i,
  input  logic [BYTE_W-1:0] addr_cfg_i,
  input  logic              crc_en_i,
  input  logic              flush_en_i,
  input  logic              app_en_i,
  input  logic [BYTE_W-1:0] rssi_i,
  input  logic [BYTE_W-2:0] lqi_i,
  input  logic [15:0]       crc_i,
  output logic              wr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rollback_o,
  output logic              commit_o,
  output logic              flush_o,
  output logic              crc_clr_o,
  output logic              crc_upd_o,
  output logic              done_o,
  output logic              restart_o,
  output logic              crc_ok_o
);
  rx_state_e         state_q, state_d, tail_st, post_crc_st;
  logic [BYTE_W-1:0] cnt_q, cnt_d;
  logic              first_q, first_d, crc_hi_seen_q, crc_hi_seen_d;
  logic              done_q, done_d, restart_q, restart_d, ok_q, ok_d;
  logic              crc_good;

  assign crc_good    = !crc_en_i || (crc_i == 16'h0000);
  assign post_crc_st = app_en_i ? ST_APP_RSSI : ST_DONE;
  assign tail_st     = crc_en_i ? ST_CRC : post_crc_st;

  always_comb begin
    state_d       = state_q;
    cnt_d         = cnt_q;
    first_d       = first_q;
    crc_hi_seen_d = crc_hi_seen_q;
    done_d        = 1'b0;
    restart_d     = 1'b0;
    ok_d          = ok_q;
    wr_o          = 1'b0;
    wr_data_o     = byte_i;
    rollback_o    = 1'b0;
    commit_o      = 1'b0;
    flush_o       = 1'b0;
    crc_clr_o     = 1'b0;
    crc_upd_o     = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (sync_i) begin
          crc_clr_o     = 1'b1;
          first_d       = 1'b1;
          crc_hi_seen_d = 1'b0;
          case (len_mode_e'(len_mode_i))
            LEN_FIXED: begin
              if (len_cfg_i == '0) state_d = tail_st;
              else begin
                state_d = ST_BODY;
                cnt_d   = len_cfg_i;
              end
            end
            LEN_VAR: state_d = ST_LEN;
            LEN_INF: state_d = ST_INF;
            default: state_d = ST_IDLE;
          endcase
        end
      end

      ST_LEN: begin
        if (byte_vld_i) begin
          if (byte_i > len_cfg_i) begin
            restart_d  = 1'b1;
            rollback_o = 1'b1;
            state_d    = ST_IDLE;
          end else begin
            wr_o      = 1'b1;
            crc_upd_o = 1'b1;
            cnt_d     = byte_i;
            state_d   = (byte_i == '0) ? tail_st : ST_BODY;
          end
        end
      end

      ST_BODY: begin
        if (byte_vld_i) begin
          if (first_q && addr_chk_i && (byte_i != addr_cfg_i)) begin
            restart_d  = 1'b1;
            rollback_o = 1'b1;
            state_d    = ST_IDLE;
          end else begin
            wr_o      = 1'b1;
            crc_upd_o = 1'b1;
            first_d   = 1'b0;
            cnt_d     = cnt_q - BYTE_W'(1);
            if (cnt_q == BYTE_W'(1)) state_d = tail_st;
          end
        end
      end

      ST_CRC: begin
        if (byte_vld_i) begin
          crc_upd_o     = 1'b1;
          crc_hi_seen_d = 1'b1;
          if (crc_hi_seen_q) state_d = post_crc_st;
        end
      end

      ST_APP_RSSI: begin
        wr_o      = 1'b1;
        wr_data_o = rssi_i;
        state_d   = ST_APP_STAT;
      end

      ST_APP_STAT: begin
        wr_o      = 1'b1;
        wr_data_o = {crc_good, lqi_i};
        state_d   = ST_DONE;
      end

      ST_DONE: begin
        done_d  = 1'b1;
        ok_d    = crc_good;
        state_d = ST_IDLE;
        if (crc_en_i && !crc_good && flush_en_i) flush_o  = 1'b1;
        else                                     commit_o = 1'b1;
      end

      ST_INF: begin
        wr_o = byte_vld_i;
        if (stop_i) begin
          commit_o = 1'b1;
          done_d   = 1'b1;
          ok_d     = 1'b1;
          state_d  = ST_IDLE;
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      cnt_q         <= '0;
      first_q       <= 1'b0;
      crc_hi_seen_q <= 1'b0;
      done_q        <= 1'b0;
      restart_q     <= 1'b0;
      ok_q          <= 1'b0;
    end else begin
      state_q       <= state_d;
      cnt_q         <= cnt_d;
      first_q       <= first_d;
      crc_hi_seen_q <= crc_hi_seen_d;
      done_q        <= done_d;
      restart_q     <= restart_d;
      ok_q          <= ok_d;
    end
  end

  assign done_o    = done_q;
  assign restart_o = restart_q;
  assign crc_ok_o  = ok_q;
endmodule

// File: rtl/rx_pkt_filter.sv
module rx_pkt_filter import rxf_pkg::*; #(
  parameter int unsigned FIFO_DEPTH = 64,
  localparam int unsigned AW = $clog2(FIFO_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  input  logic          stop_i,
  input  logic [1:0]    len_mode_i,
  input  logic [7:0]    len_cfg_i,
  input  logic          addr_chk_i,
  input  logic [7:0]    addr_cfg_i,
  input  logic          crc_en_i,
  input  logic          flush_en_i,
  input  logic          app_en_i,
  input  logic [7:0]    rssi_i,
  input  logic [6:0]    lqi_i,
  output logic          fifo_we_o,
  output logic [AW-1:0] fifo_waddr_o,
  output logic [7:0]    fifo_wdata_o,
  output logic [AW-1:0] fifo_cptr_o,
  output logic          fifo_flush_o,
  output logic          pkt_done_o,
  output logic          crc_ok_o,
  output logic          restart_o
);
  logic              wr, rollback, commit, flush, crc_clr, crc_upd;
  logic [BYTE_W-1:0] wr_data;
  logic [15:0]       crc;

  rxf_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .stop_i     (stop_i),
    .len_mode_i (len_mode_i),
    .len_cfg_i  (len_cfg_i),
    .addr_chk_i (addr_chk_i),
    .addr_cfg_i (addr_cfg_i),
    .crc_en_i   (crc_en_i),
    .flush_en_i (flush_en_i),
    .app_en_i   (app_en_i),
    .rssi_i     (rssi_i),
    .lqi_i      (lqi_i),
    .crc_i      (crc),
    .wr_o       (wr),
    .wr_data_o  (wr_data),
    .rollback_o (rollback),
    .commit_o   (commit),
    .flush_o    (flush),
    .crc_clr_o  (crc_clr),
    .crc_upd_o  (crc_upd),
    .done_o     (pkt_done_o),
    .restart_o  (restart_o),
    .crc_ok_o   (crc_ok_o)
  );

  rxf_crc16 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .upd_i  (crc_upd),
    .data_i (byte_i),
    .crc_o  (crc)
  );

  rxf_wptr #(.DEPTH(FIFO_DEPTH)) u_wptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr),
    .wr_data_i  (wr_data),
    .rollback_i (rollback),
    .commit_i   (commit),
    .flush_i    (flush),
    .we_o       (fifo_we_o),
    .waddr_o    (fifo_waddr_o),
    .wdata_o    (fifo_wdata_o),
    .cptr_o     (fifo_cptr_o),
    .flush_o    (fifo_flush_o)
  );
endmodule

// File: rtl/rx_pkt_filter_chk.sv
module rx_pkt_filter_chk #(
  parameter int unsigned AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fifo_we_o,
  input logic [AW-1:0] fifo_cptr_o,
  input logic          fifo_flush_o,
  input logic          pkt_done_o,
  input logic          crc_ok_o,
  input logic          restart_o
);
  // R3 / R5: a discarding byte is never written
  a_r3_restart_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> !fifo_we_o);

  a_r5_restart_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o);

  a_r2_done_excludes_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pkt_done_o && restart_o));

  a_r4_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |=> !pkt_done_o);

  a_r7_flush_needs_bad_crc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_flush_o |-> (pkt_done_o && !crc_ok_o));

  a_r9_cptr_moves_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fifo_cptr_o) |-> (pkt_done_o || fifo_flush_o));

  a_r6_crc_ok_changes_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(crc_ok_o) |-> pkt_done_o);
endmodule

bind rx_pkt_filter rx_pkt_filter_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fifo_we_o    (fifo_we_o),
  .fifo_cptr_o  (fifo_cptr_o),
  .fifo_flush_o (fifo_flush_o),
  .pkt_done_o   (pkt_done_o),
  .crc_ok_o     (crc_ok_o),
  .restart_o    (restart_o)
);

// File: tb/rx_pkt_filter_tb_top.sv
module rx_pkt_filter_tb_top;
  localparam int DEPTH = 64;
  localparam int AW = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          sync = 1'b0, bvld = 1'b0, stop = 1'b0;
  logic [7:0]    bdat = '0;
  logic [1:0]    len_mode = '0;
  logic [7:0]    len_cfg = '0, addr_cfg = 8'h3C, rssi = 8'hA5;
  logic          addr_chk = 1'b0, crc_en = 1'b0, flush_en = 1'b0, app_en = 1'b0;
  logic [6:0]    lqi = 7'h2B;
  logic          fifo_we, fifo_flush, pkt_done, crc_ok, restart;
  logic [AW-1:0] fifo_waddr, fifo_cptr;
  logic [7:0]    fifo_wdata;

  rx_pkt_filter #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .byte_vld_i(bvld), .byte_i(bdat),
    .stop_i(stop), .len_mode_i(len_mode), .len_cfg_i(len_cfg), .addr_chk_i(addr_chk),
    .addr_cfg_i(addr_cfg), .crc_en_i(crc_en), .flush_en_i(flush_en), .app_en_i(app_en),
    .rssi_i(rssi), .lqi_i(lqi), .fifo_we_o(fifo_we), .fifo_waddr_o(fifo_waddr),
    .fifo_wdata_o(fifo_wdata), .fifo_cptr_o(fifo_cptr), .fifo_flush_o(fifo_flush),
    .pkt_done_o(pkt_done), .crc_ok_o(crc_ok), .restart_o(restart)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0]    cap_d[$];
  logic [AW-1:0] cap_a[$];
  int done_n, rst_cnt, flush_n, done_cyc, restart_cyc;
  int m_wptr = 0, m_cptr = 0;

  always @(negedge clk) if (rst_n) begin
    if (fifo_we) begin cap_d.push_back(fifo_wdata); cap_a.push_back(fifo_waddr); end
    if (pkt_done) begin done_n++; done_cyc = cyc; end
    if (restart) begin rst_cnt++; restart_cyc = cyc; end
    if (fifo_flush) flush_n++;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_b(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h8005;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  task automatic clear_mon;
    cap_d.delete(); cap_a.delete();
    done_n = 0; rst_cnt = 0; flush_n = 0; done_cyc = -1; restart_cyc = -1;
  endtask

  // expected writes and outcome: 0 done, 1 restart, 2 flush
  task automatic model(input logic [7:0] s[$], output logic [7:0] w[$], output int outc,
                       output bit ok, output int ab);
    int idx = 0;
    int L;
    logic [15:0] c = 16'hFFFF;
    w.delete(); ok = 1'b1; ab = 0; outc = 0;
    if (len_mode == 2'd1) begin
      L = s[0];
      if (L > len_cfg) begin outc = 1; return; end
      w.push_back(s[0]); c = crc_b(c, s[0]); idx = 1;
    end else L = len_cfg;
    if (addr_chk && L > 0 && s[idx] != addr_cfg) begin outc = 1; ab = idx; return; end
    for (int k = 0; k < L; k++) begin w.push_back(s[idx+k]); c = crc_b(c, s[idx+k]); end
    if (crc_en) ok = ({s[idx+L], s[idx+L+1]} == c);
    if (app_en) begin w.push_back(rssi); w.push_back({ok, lqi}); end
    outc = (crc_en && !ok && flush_en) ? 2 : 0;
  endtask

  // stream after sync: [len] payload [crc hi, lo]
  task automatic build(input int len_field, input int L, input bit addr_good, input bit bad_crc,
                       output logic [7:0] s[$]);
    logic [15:0] c = 16'hFFFF;
    s.delete();
    if (len_mode == 2'd1) begin s.push_back(8'(len_field)); c = crc_b(c, 8'(len_field)); end
    for (int k = 0; k < L; k++) begin
      logic [7:0] b = 8'($urandom);
      if (k == 0) b = addr_good ? addr_cfg : (addr_cfg ^ 8'h5A);
      s.push_back(b); c = crc_b(c, b);
    end
    if (crc_en) begin
      if (bad_crc) c = c ^ 16'h0100;
      s.push_back(c[15:8]); s.push_back(c[7:0]);
    end
  endtask

  task automatic send(input logic [7:0] s[$], output int dcyc[$]);
    dcyc.delete();
    @(negedge clk); sync = 1'b1;
    @(negedge clk); sync = 1'b0;
    foreach (s[i]) begin
      repeat ($urandom_range(0, 2)) @(negedge clk);
      bvld = 1'b1; bdat = s[i]; dcyc.push_back(cyc);
      @(negedge clk); bvld = 1'b0;
    end
  endtask

  task automatic run_pkt(input string tag, input logic [7:0] s[$]);
    logic [7:0] w[$];
    int outc, ab, n;
    bit ok;
    int dcyc[$];
    model(s, w, outc, ok, ab);
    clear_mon();
    send(s, dcyc);
    repeat (8) @(negedge clk);
    chk(tag, "write count", cap_d.size(), w.size());
    n = (cap_d.size() < w.size()) ? cap_d.size() : w.size();
    for (int i = 0; i < n; i++) begin
      chk(app_en && i >= w.size() - 2 ? "R8" : tag, "write data", cap_d[i], w[i]);
      chk(tag, "write addr", cap_a[i], (m_wptr + i) % DEPTH);
    end
    if (outc == 1) begin
      chk(ab == 0 && len_mode == 2'd1 ? "R3" : "R5", "restart count", rst_cnt, 1);
      chk("R3", "done on discard", done_n, 0);
      if (dcyc.size() > ab) chk("R5", "restart latency", restart_cyc - dcyc[ab], 1);
      m_wptr = m_cptr;
    end else begin
      chk("R6", "done count", done_n, 1);
      chk("R6", "crc_ok", crc_ok, ok);
      chk("R7", "flush count", flush_n, outc == 2);
      chk("R3", "restart on good packet", rst_cnt, 0);
      if (s.size() > 0) chk("R8", "done latency", done_cyc - dcyc[$], app_en ? 4 : 2);
      if (outc == 2) begin m_wptr = 0; m_cptr = 0; end
      else begin m_wptr = (m_wptr + w.size()) % DEPTH; m_cptr = m_wptr; end
    end
    chk("R9", "commit pointer", fifo_cptr, m_cptr);
  endtask

  task automatic cfg(input logic [1:0] m, input int lc, input bit ac, input bit ce,
                     input bit fe, input bit ap);
    @(negedge clk);
    len_mode = m; len_cfg = 8'(lc); addr_chk = ac; crc_en = ce; flush_en = fe; app_en = ap;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] s[$];
    int dcyc[$];
    int stop_cyc;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "we after reset", fifo_we, 0);
    chk("R1", "done after reset", pkt_done, 0);
    chk("R1", "restart after reset", restart, 0);
    chk("R1", "flush after reset", fifo_flush, 0);
    chk("R1", "crc_ok after reset", crc_ok, 0);
    chk("R1", "cptr after reset", fifo_cptr, 0);

    // R2 fixed, plain
    cfg(2'd0, 4, 0, 0, 0, 0); build(0, 4, 1, 0, s); run_pkt("R2", s);
    // R3 variable with CRC and status bytes (R6, R8)
    cfg(2'd1, 10, 0, 1, 0, 1); build(5, 5, 1, 0, s); run_pkt("R3", s);
    // R3 oversize length
    build(20, 3, 1, 0, s); run_pkt("R3", s);
    // R3 length equal to maximum
    cfg(2'd1, 10, 0, 1, 0, 0); build(10, 10, 1, 0, s); run_pkt("R3", s);
    // R3 zero length
    build(0, 0, 1, 0, s); run_pkt("R3", s);
    // R5 address mismatch after length byte, then a good addressed packet
    cfg(2'd1, 12, 1, 1, 0, 0); build(6, 6, 0, 0, s); run_pkt("R5", s);
    build(6, 6, 1, 0, s); run_pkt("R5", s);
    // R6 bad CRC kept
    cfg(2'd0, 7, 0, 1, 0, 1); build(0, 7, 1, 1, s); run_pkt("R6", s);
    // R7 bad CRC flushed
    cfg(2'd0, 7, 0, 1, 1, 1); build(0, 7, 1, 1, s); run_pkt("R7", s);

    // R4 infinite
    cfg(2'd2, 0, 0, 0, 0, 0);
    clear_mon();
    s.delete(); for (int i = 0; i < 7; i++) s.push_back(8'(8'h40 + i));
    send(s, dcyc);
    @(negedge clk); stop = 1'b1; stop_cyc = cyc;
    @(negedge clk); stop = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4", "inf write count", cap_d.size(), 7);
    for (int i = 0; i < 7 && i < cap_d.size(); i++) begin
      chk("R4", "inf data", cap_d[i], s[i]);
      chk("R4", "inf addr", cap_a[i], (m_wptr + i) % DEPTH);
    end
    chk("R4", "inf done", done_n, 1);
    chk("R4", "inf done latency", done_cyc - stop_cyc, 1);
    chk("R4", "inf crc_ok", crc_ok, 1);
    m_wptr = (m_wptr + 7) % DEPTH; m_cptr = m_wptr;
    chk("R9", "inf cptr", fifo_cptr, m_cptr);

    // R4 disabled mode ignores sync
    cfg(2'd3, 5, 0, 0, 0, 0);
    clear_mon();
    send(s, dcyc);
    repeat (6) @(negedge clk);
    chk("R4", "off mode writes", cap_d.size(), 0);
    chk("R4", "off mode done", done_n + rst_cnt, 0);
    chk("R9", "off mode cptr", fifo_cptr, m_cptr);

    // random packets
    for (int t = 0; t < 80; t++) begin
      int L, lf, mx;
      bit var_mode;
      var_mode = 1'($urandom);
      mx = $urandom_range(1, 12);
      cfg(var_mode ? 2'd1 : 2'd0, mx, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      @(negedge clk);
      rssi = 8'($urandom); lqi = 7'($urandom);
      L = var_mode ? $urandom_range(0, mx) : mx;
      lf = ($urandom_range(0, 7) == 0) ? mx + 1 + $urandom_range(0, 5) : L;
      build(lf, L, $urandom_range(0, 5) != 0, $urandom_range(0, 4) == 0, s);
      run_pkt(var_mode ? "R3" : "R2", s);
    end

    summary();
    $finish;
  end
endmodule